// File: doc/BRIEF.md
# Two-Stage Redial Register Controller

This block keeps the number dialed on the current call in a 32-entry redial buffer and plays it back when the user asks for a redial. Every accepted entry is written in the order it arrives, whether it was keyed by hand or recalled from a stored location. The entries can be digits, star, hash, pause or the pulse-to-tone marker. When a call goes past 32 entries, dialing itself goes on, but the buffer is flagged as inhibited and redial does nothing until a new call writes fresh content.

Playback runs in two stages, split at the pulse-to-tone marker. The first redial press of a call plays from the start of the buffer up to, but not including, the first marker. A second press plays the marker and everything after it. Each entry goes to the signalling stage with a valid/ready handshake. Entries keyed after a replay are added to the end of the stored number. A new off-hook event arms the buffer so that the next keyed entry replaces the old content.

The controller has two states. IDLE accepts entries and redial requests. PLAY presents entries to the signalling stage. Three transitions connect them:
- start: IDLE to PLAY, on a redial request that has something to play.
- finish: PLAY to IDLE, on the handshake of the last entry of the stage.
- abort: PLAY to IDLE, on an off-hook event.

Top module: `redial_ctrl`

## Requirements
- R1: Accepted entries are stored in arrival order. `stored` reports how many entries are held, and it never exceeds 32.
- R2: The first entry accepted after an off-hook event, or after reset, replaces the old content when no replay has started since that event. After it, `stored` reads 1 and `inhibit` reads 0.
- R3: An entry accepted while `stored` is 32 sets `inhibit`, and `stored` stays at 32. While `inhibit` is set, further entries are ignored and a redial request produces no output.
- R4: Entry codes are 0 to 9 for digits, 10 for star, 11 for hash, 12 for pause and 13 for the pulse-to-tone marker. Every code is stored and replayed unchanged.
- R5: If no marker stands at an index above 0, a redial request plays every stored entry in order starting at index 0. Each entry is presented one at a time. `play_vld` rises one cycle after the request, and `play_code` holds steady until `play_rdy` is seen.
- R6: The first replay of a call stops before the first marker found at an index above 0. The next redial request plays from that marker through to the last entry.
- R7: Entries accepted after a replay has started on the call are appended after the existing content. They are included in the next replay.
- R8: A redial request produces no output when the buffer is empty or when every stored entry has already been played on this call.
- R9: An off-hook event ends any replay, so `play_vld` is low in the next cycle. It also rearms the first stage, so the next redial request starts again at index 0.
- R10: While a replay is in progress, entry strobes and redial requests are ignored.
- R11: After reset, `stored` is 0, `inhibit` is 0 and `play_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hook_evt | input | 1 | One-cycle pulse marking a new off-hook event |
| ent_vld | input | 1 | Entry strobe |
| ent_code | input | 4 | Entry code (digit, star, hash, pause, marker) |
| redial_req | input | 1 | One-cycle redial request |
| play_vld | output | 1 | A replayed entry is presented |
| play_code | output | 4 | Code of the presented entry |
| play_rdy | input | 1 | Signalling stage accepts the presented entry |
| busy | output | 1 | Replay in progress |
| inhibit | output | 1 | Call exceeded buffer length; redial blocked |
| stored | output | 6 | Number of stored entries |

## Verification
A bad write address or length count shows up in the next replay as a missing, repeated or reordered code. `stored` also reveals it one cycle after the entry. A replay pointer left at the wrong place after an off-hook event, or a lost stage flag, makes the first code of the next replay wrong, or moves where the replay stops relative to the marker. These errors are visible one cycle after the redial request. A stuck inhibit flag or a stale PLAY state shows up as output on a request that should be silent, or as missing output on one that should play, within one cycle of the request.

// File: rtl/redial_pkg.sv
package redial_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_MARK = 4'd13;

    typedef enum logic {
        ST_IDLE,
        ST_PLAY
    } rd_state_t;
endpackage

// File: rtl/redial_store.sv
module redial_store #(
    parameter int DEPTH = 32,
    parameter int CW    = 4,
    parameter int LW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [LW-1:0] raddr_a,
    output logic [CW-1:0] rdata_a,
    input  logic [LW-1:0] raddr_b,
    output logic [CW-1:0] rdata_b
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LW-1:0] LIMIT = LW'(DEPTH);

    logic [CW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && waddr < LIMIT) begin
            cells[waddr[AW-1:0]] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (raddr_a < LIMIT) ? cells[raddr_a[AW-1:0]] : '0;
        rdata_b = (raddr_b < LIMIT) ? cells[raddr_b[AW-1:0]] : '0;
    end
endmodule

// File: rtl/redial_track.sv
module redial_track #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_en,
    input  logic          fresh,
    output logic          we,
    output logic [LW-1:0] waddr,
    output logic [LW-1:0] len,
    output logic          inhibit
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    always_comb begin
        we    = key_en && (fresh || (!inhibit && len < FULL));
        waddr = fresh ? '0 : len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len     <= '0;
            inhibit <= 1'b0;
        end else if (key_en) begin
            if (fresh) begin
                len     <= LW'(1);
                inhibit <= 1'b0;
            end else if (!inhibit) begin
                if (len == FULL) begin
                    inhibit <= 1'b1;
                end else begin
                    len <= len + LW'(1);
                end
            end
        end
    end

    assert_len_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        len <= FULL);

    assert_inhibit_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> len == FULL);
endmodule

// File: rtl/redial_ctrl.sv
module redial_ctrl
    import redial_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hook_evt,
    input  logic              ent_vld,
    input  logic [CODE_W-1:0] ent_code,
    input  logic              redial_req,
    output logic              play_vld,
    output logic [CODE_W-1:0] play_code,
    input  logic              play_rdy,
    output logic              busy,
    output logic              inhibit,
    output logic [LW-1:0]     stored
);
    rd_state_t         state, state_nx;
    logic [LW-1:0]     rptr;
    logic [LW-1:0]     rnext;
    logic              fresh, first, stg1;
    logic              key_en, start, hs, last;
    logic              we;
    logic [LW-1:0]     waddr;
    logic [CODE_W-1:0] code_a, code_b;

    assign rnext  = rptr + LW'(1);
    assign key_en = ent_vld && (state == ST_IDLE) && !hook_evt;
    assign start  = redial_req && (state == ST_IDLE) && !hook_evt
                    && !inhibit && (rptr < stored);
    assign hs     = (state == ST_PLAY) && play_rdy;
    assign last   = (rnext == stored) || (stg1 && code_b == CODE_MARK);

    redial_track #(.DEPTH(DEPTH), .LW(LW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_en  (key_en),
        .fresh   (fresh),
        .we      (we),
        .waddr   (waddr),
        .len     (stored),
        .inhibit (inhibit)
    );

    redial_store #(.DEPTH(DEPTH), .CW(CODE_W), .LW(LW)) u_store (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (ent_code),
        .raddr_a (rptr),
        .rdata_a (code_a),
        .raddr_b (rnext),
        .rdata_b (code_b)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PLAY;
            ST_PLAY: begin
                if (hook_evt)       state_nx = ST_IDLE;   // abort
                else if (hs && last) state_nx = ST_IDLE;  // finish
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // replay pointer and call flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            fresh <= 1'b1;
            first <= 1'b1;
            stg1  <= 1'b0;
        end else if (hook_evt) begin
            rptr  <= '0;
            fresh <= 1'b1;
            first <= 1'b1;
        end else if (start) begin
            fresh <= 1'b0;
            first <= 1'b0;
            stg1  <= first;
        end else if (key_en && fresh) begin
            fresh <= 1'b0;
            rptr  <= '0;
        end else if (hs) begin
            rptr  <= rnext;
        end
    end

    // outputs
    always_comb begin
        play_vld  = (state == ST_PLAY);
        busy      = (state == ST_PLAY);
        play_code = code_a;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        play_vld && !play_rdy && !hook_evt |=> play_vld && $stable(play_code));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hook_evt |=> !play_vld);

    assert_play_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        play_vld |-> !inhibit && rptr < stored);

    assert_keys_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        play_vld && !hook_evt |=> $stable(stored));
endmodule

// File: tb/sim_redial_ctrl.sv
module sim_redial_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] MARK = 4'd13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hook_evt = 1'b0, ent_vld = 1'b0, redial_req = 1'b0, play_rdy = 1'b0;
    logic [3:0] ent_code = '0;
    logic       play_vld, busy, inhibit;
    logic [3:0] play_code;
    logic [5:0] stored;

    int checks = 0, fails = 0, cyc = 0, gn = 0;
    logic [3:0] got [0:69];

    always #(CLK_PERIOD/2) clk = ~clk;

    redial_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hook_evt(hook_evt), .ent_vld(ent_vld),
        .ent_code(ent_code), .redial_req(redial_req), .play_vld(play_vld),
        .play_code(play_code), .play_rdy(play_rdy), .busy(busy),
        .inhibit(inhibit), .stored(stored)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ecode(input int i, input int n);
        return (i * 7 + n) % 13;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic hook();
        hook_evt = 1'b1; @(negedge clk); hook_evt = 1'b0;
    endtask

    task automatic key(input int c);
        ent_vld = 1'b1; ent_code = 4'(c); @(negedge clk); ent_vld = 1'b0;
    endtask

    task automatic press();
        redial_req = 1'b1; @(negedge clk); redial_req = 1'b0;
    endtask

    task automatic collect();
        gn = 0;
        for (int g = 0; g < 70; g++) begin
            if (!play_vld) break;
            got[gn] = play_code;
            if (gn % 2 == 1) begin
                @(negedge clk);
                chk(play_vld && play_code == got[gn], "R5 hold", int'(play_code), int'(got[gn]));
            end
            play_rdy = 1'b1; @(negedge clk); play_rdy = 1'b0;
            gn++;
        end
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(stored == 0 && !inhibit && !play_vld, "R11 reset", int'(stored), 0);
        rst_n = 1'b1;
        @(negedge clk);
        press(); collect();
        chk(gn == 0, "R8 empty", gn, 0);

        // sweep lengths 1..32, marker at n/2 for n>=3
        for (int n = 1; n <= 32; n++) begin
            int m;
            int l1;
            m = (n >= 3) ? n / 2 : 0;
            hook();
            for (int i = 0; i < n; i++) key((m > 0 && i == m) ? int'(MARK) : ecode(i, n));
            chk(stored == 6'(n), "R1 count", int'(stored), n);
            chk(!inhibit, "R2 inhibit", int'(inhibit), 0);
            press(); collect();
            l1 = (m > 0) ? m : n;
            chk(gn == l1, "R6 stage1 length", gn, l1);
            for (int k = 0; k < l1 && k < gn; k++)
                chk(got[k] == 4'(ecode(k, n)), "R4 R5 stage1 code", int'(got[k]), ecode(k, n));
            if (m > 0) begin
                press(); collect();
                chk(gn == n - m, "R6 stage2 length", gn, n - m);
                if (gn > 0) chk(got[0] == MARK, "R6 marker first", int'(got[0]), int'(MARK));
                for (int k = 1; k < gn; k++)
                    chk(got[k] == 4'(ecode(m + k, n)), "R6 stage2 code", int'(got[k]), ecode(m + k, n));
            end
            press(); collect();
            chk(gn == 0, "R8 exhausted", gn, 0);
        end

        // append after replay
        hook(); key(3); key(4);
        press(); collect();
        chk(gn == 2, "R5 short replay", gn, 2);
        key(5);
        chk(stored == 3, "R7 append count", int'(stored), 3);
        hook(); press(); collect();
        chk(gn == 3 && got[2] == 4'd5, "R7 appended replay", int'(got[2]), 5);

        // overflow
        hook();
        for (int i = 0; i < 33; i++) key(i % 10);
        chk(inhibit && stored == 32, "R3 overflow", int'(stored), 32);
        key(7);
        chk(stored == 32, "R3 ignored entry", int'(stored), 32);
        press(); collect();
        chk(gn == 0, "R3 redial blocked", gn, 0);
        hook(); key(9);
        chk(stored == 1 && !inhibit, "R2 fresh clears", int'(stored), 1);

        // abort and ignored strobes during replay
        hook(); key(1); key(2); key(3);
        hook(); press();
        chk(play_vld && play_code == 4'd1, "R5 first code", int'(play_code), 1);
        ent_vld = 1'b1; ent_code = 4'd8; redial_req = 1'b1; @(negedge clk);
        ent_vld = 1'b0; redial_req = 1'b0;
        chk(stored == 3, "R10 key ignored", int'(stored), 3);
        hook_evt = 1'b1; @(negedge clk); hook_evt = 1'b0;
        chk(!play_vld && !busy, "R9 abort", int'(play_vld), 0);
        press(); collect();
        chk(gn == 3 && got[0] == 4'd1 && got[2] == 4'd3, "R9 restart at 0", gn, 3);
        press(); collect();
        chk(gn == 0, "R10 no extra replay", gn, 0);

        summary();
    end
endmodule